// File: doc/BRIEF.md
# Volume, Tone and Mute Register Decoder

This block sits behind a serial-bus receiver in a two-channel audio processor. Each completed bus write gives it one sub-address byte and one data byte. The sub-address is not a plain register index. It is a set of enable bits, so one transfer can update several control registers at the same time. The data byte is then decoded into ready-to-use control values:

- a per-channel attenuation in dB, with a separate flag for full (infinite) attenuation;
- signed bass and treble gains in dB;
- a mute state.

The input is a valid/ready transfer port that never applies back-pressure. `in_ready` is tied high, so every cycle with `in_valid` high is one accepted transfer. The upstream receiver needs no holding logic. Every output is registered. Each control value has a one-cycle pulse that marks a change, so the analog switch drivers can act only when a setting really moves. Tone writes that carry an unused code are dropped and reported on an error pulse.

Top module: `avc_regs_top`

## Requirements
- R1: While `rst_n` is low, and after it is released, both channels show infinite attenuation (`chX_att_inf`=1, `chX_att_db`=127). Bass and treble read 0 dB, mute is off, and every pulse output is 0.
- R2: `in_ready` is always 1. A transfer is accepted in each cycle with `in_valid`=1, and its effect shows on the outputs from the next clock edge. With `in_valid`=0, no output register changes.
- R3: Every accepted transfer sets `mute_on` to sub-address bit 4. While bit 4 is 1, the transfer writes no volume or tone register, whatever sub-address bits 3..0 hold.
- R4: A volume write takes place only when bit 4 is 0 and bits 3 and 2 are both 0. Bit 0 then writes channel 1 and bit 1 writes channel 2. With both bits set, both channels take the same value.
- R5: Data bits 4..0 form a coarse code n. For n=0..21 the coarse value is 2n dB. For n=22..30 it is 46+4(n-22) dB. n=31 means infinite attenuation, shown as inf flag 1 with the dB field at 127.
- R6: Data bits 6..5 form a fine value f of 0..3 dB, which is added to the coarse value. When f is 2 or 3 and the coarse value is 42 dB or more, f counts as 0. Data bit 7 has no effect on volume, and f has no effect when n=31.
- R7: A tone write takes place only when bit 4 is 0 and bits 1 and 0 are both 0. Bit 2 writes bass from data bits 3..0, and bit 3 writes treble from data bits 7..4. Both may be written in the same transfer.
- R8: A tone code is sign-magnitude. Bit 3 is the sign (1 = cut) and bits 2..0 are a step count s from 0 to 6. The gain is ±2s dB, which gives a range of -12..+12 dB.
- R9: The codes 0111, 1111 and 1000 are unused. An enabled field that carries one of them leaves its register unchanged and raises `tone_err` for one cycle. The other field of the same transfer is still written if it is valid.
- R10: Each of `ch1_chg`, `ch2_chg`, `bass_chg`, `treble_chg` and `mute_chg` is 1 for exactly the one cycle in which its register takes a new value that differs from the old one. A write of the same value gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Transfer present |
| in_ready | output | 1 | Always 1, no back-pressure |
| in_sub | input | 8 | Sub-address enable bits |
| in_data | input | 8 | Data byte |
| ch1_att_db | output | 7 | Channel 1 attenuation in dB (127 when infinite) |
| ch1_att_inf | output | 1 | Channel 1 infinite attenuation |
| ch2_att_db | output | 7 | Channel 2 attenuation in dB (127 when infinite) |
| ch2_att_inf | output | 1 | Channel 2 infinite attenuation |
| bass_db | output | 5 | Signed bass gain in dB |
| treble_db | output | 5 | Signed treble gain in dB |
| mute_on | output | 1 | Mute state |
| ch1_chg | output | 1 | Channel 1 value changed |
| ch2_chg | output | 1 | Channel 2 value changed |
| bass_chg | output | 1 | Bass value changed |
| treble_chg | output | 1 | Treble value changed |
| mute_chg | output | 1 | Mute state changed |
| tone_err | output | 1 | Unused tone code rejected |

## Verification
The in-line assertions check the gating rules on every cycle:

- the registers stay still in cycles without a transfer;
- mute follows bit 4, and a muting transfer leaves the other registers alone;
- volume and tone registers stay still when their blocking sub-address bits are set;
- a change pulse comes only with a real value change;
- an error pulse comes only after a transfer;
- tone gains stay even and within ±12 dB.

The values themselves need the bench's directed scenarios. These are the full sweep of coarse codes on both channels, and the fine step near the 42 dB limit and at the top code. They also cover every tone code in each field, the single-channel and mixed enable combinations, and the mix of a rejected tone field with an accepted one.

// File: rtl/avc_pkg.sv
package avc_pkg;
  localparam int SUB_W    = 8;
  localparam int DAT_W    = 8;
  localparam int COARSE_W = 5;
  localparam int FINE_W   = 2;
  localparam int ATT_W    = 7;
  localparam int TONE_W   = 4;
  localparam int GAIN_W   = 5;
  localparam int NUM_CH   = 2;
  localparam int NUM_TONE = 2;

  typedef struct packed {
    logic             inf;
    logic [ATT_W-1:0] db;
  } att_t;

  typedef logic signed [GAIN_W-1:0] gain_t;

  typedef struct packed {
    logic                mute;
    logic [NUM_CH-1:0]   vol_we;
    logic [NUM_TONE-1:0] tone_we;  // [0] bass, [1] treble
  } wr_sel_t;
endpackage

// File: rtl/avc_sub_decode.sv
module avc_sub_decode
  import avc_pkg::*;
#(
  parameter int MUTE_BIT = 4
) (
  input  logic [SUB_W-1:0] sub,
  output wr_sel_t          sel
);
  localparam int VOL_BLK_LO  = NUM_CH;
  localparam int TONE_BLK_LO = 0;

  logic vol_open;
  logic tone_open;

  // Volume opens when the tone enables are clear; tone opens when the channel enables are clear.
  assign vol_open  = !sub[MUTE_BIT] && (sub[VOL_BLK_LO +: NUM_TONE] == '0);
  assign tone_open = !sub[MUTE_BIT] && (sub[TONE_BLK_LO +: NUM_CH] == '0);

  always_comb begin
    sel.mute = sub[MUTE_BIT];
    for (int c = 0; c < NUM_CH; c++) begin
      sel.vol_we[c] = vol_open && sub[c];
    end
    for (int t = 0; t < NUM_TONE; t++) begin
      sel.tone_we[t] = tone_open && sub[VOL_BLK_LO + t];
    end
  end
endmodule

// File: rtl/avc_vol_decode.sv
module avc_vol_decode
  import avc_pkg::*;
#(
  parameter int SMALL_STEP_DB = 2,
  parameter int LARGE_STEP_DB = 4,
  parameter int KNEE_CODE     = 22,
  parameter int KNEE_DB       = 46,
  parameter int FINE_CAP_DB   = 42
) (
  input  logic [COARSE_W-1:0] code,
  input  logic [FINE_W-1:0]   fine,
  output att_t                att
);
  localparam int INF_CODE      = (1 << COARSE_W) - 1;
  localparam int FINE_FREE_MAX = 1;

  logic [ATT_W-1:0] code_w;
  logic [ATT_W-1:0] coarse_db;
  logic [ATT_W-1:0] fine_db;

  assign code_w = ATT_W'(code);

  always_comb begin
    if (code_w < ATT_W'(KNEE_CODE)) begin
      coarse_db = code_w * ATT_W'(SMALL_STEP_DB);
    end else begin
      coarse_db = ATT_W'(KNEE_DB) + (code_w - ATT_W'(KNEE_CODE)) * ATT_W'(LARGE_STEP_DB);
    end
  end

  always_comb begin
    fine_db = ATT_W'(fine);
    if ((coarse_db >= ATT_W'(FINE_CAP_DB)) && (fine_db > ATT_W'(FINE_FREE_MAX))) begin
      fine_db = '0;
    end
  end

  always_comb begin
    if (code == COARSE_W'(INF_CODE)) begin
      att.inf = 1'b1;
      att.db  = '1;
    end else begin
      att.inf = 1'b0;
      att.db  = coarse_db + fine_db;
    end
  end
endmodule

// File: rtl/avc_tone_decode.sv
module avc_tone_decode
  import avc_pkg::*;
#(
  parameter int STEP_DB   = 2,
  parameter int MAX_STEPS = 6
) (
  input  logic [TONE_W-1:0] code,
  output gain_t             gain,
  output logic              ok
);
  localparam int MAG_W = TONE_W - 1;

  logic              neg;
  logic [MAG_W-1:0]  mag;
  logic [GAIN_W-1:0] size_db;

  assign neg     = code[TONE_W-1];
  assign mag     = code[MAG_W-1:0];
  assign size_db = GAIN_W'(mag) * GAIN_W'(STEP_DB);

  // A step count above the limit is unused, and so is a cut of zero steps.
  assign ok   = (mag <= MAG_W'(MAX_STEPS)) && !(neg && (mag == '0));
  assign gain = neg ? -$signed(size_db) : $signed(size_db);
endmodule

// File: rtl/avc_regs_top.sv
module avc_regs_top
  import avc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SUB_W-1:0]  in_sub,
  input  logic [DAT_W-1:0]  in_data,
  output logic [ATT_W-1:0]  ch1_att_db,
  output logic              ch1_att_inf,
  output logic [ATT_W-1:0]  ch2_att_db,
  output logic              ch2_att_inf,
  output logic [GAIN_W-1:0] bass_db,
  output logic [GAIN_W-1:0] treble_db,
  output logic              mute_on,
  output logic              ch1_chg,
  output logic              ch2_chg,
  output logic              bass_chg,
  output logic              treble_chg,
  output logic              mute_chg,
  output logic              tone_err
);
  localparam int MUTE_BIT = 4;
  localparam int FINE_LO  = COARSE_W;

  logic                         acc;
  wr_sel_t                      sel;
  att_t                         vol_new;
  att_t  [NUM_CH-1:0]           att_q;
  logic  [NUM_CH-1:0]           att_chg_q;
  gain_t [NUM_TONE-1:0]         tone_new;
  logic  [NUM_TONE-1:0]         tone_ok;
  gain_t [NUM_TONE-1:0]         tone_q;
  logic  [NUM_TONE-1:0]         tone_chg_q;
  logic  [NUM_TONE-1:0]         tone_err_q;
  logic                         mute_q;
  logic                         mute_chg_q;

  assign in_ready = 1'b1;
  assign acc      = in_valid && in_ready;

  avc_sub_decode #(.MUTE_BIT(MUTE_BIT)) u_sub (
    .sub (in_sub),
    .sel (sel)
  );

  avc_vol_decode u_vol (
    .code (in_data[COARSE_W-1:0]),
    .fine (in_data[FINE_LO +: FINE_W]),
    .att  (vol_new)
  );

  // One attenuation register per channel, all fed by the same decoded value.
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        att_q[c]     <= '{inf: 1'b1, db: '1};
        att_chg_q[c] <= 1'b0;
      end else begin
        att_chg_q[c] <= 1'b0;
        if (acc && sel.vol_we[c]) begin
          att_q[c]     <= vol_new;
          att_chg_q[c] <= (vol_new != att_q[c]);
        end
      end
    end
  end

  // Tone fields: index 0 is bass (low nibble), index 1 is treble (high nibble).
  for (genvar t = 0; t < NUM_TONE; t++) begin : g_tone
    avc_tone_decode u_tone (
      .code (in_data[t*TONE_W +: TONE_W]),
      .gain (tone_new[t]),
      .ok   (tone_ok[t])
    );

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tone_q[t]     <= '0;
        tone_chg_q[t] <= 1'b0;
        tone_err_q[t] <= 1'b0;
      end else begin
        tone_chg_q[t] <= 1'b0;
        tone_err_q[t] <= 1'b0;
        if (acc && sel.tone_we[t]) begin
          if (tone_ok[t]) begin
            tone_q[t]     <= tone_new[t];
            tone_chg_q[t] <= (tone_new[t] != tone_q[t]);
          end else begin
            tone_err_q[t] <= 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mute_q     <= 1'b0;
      mute_chg_q <= 1'b0;
    end else begin
      mute_chg_q <= 1'b0;
      if (acc) begin
        mute_q     <= sel.mute;
        mute_chg_q <= (sel.mute != mute_q);
      end
    end
  end

  assign ch1_att_db  = att_q[0].db;
  assign ch1_att_inf = att_q[0].inf;
  assign ch2_att_db  = att_q[1].db;
  assign ch2_att_inf = att_q[1].inf;
  assign bass_db     = tone_q[0];
  assign treble_db   = tone_q[1];
  assign mute_on     = mute_q;
  assign ch1_chg     = att_chg_q[0];
  assign ch2_chg     = att_chg_q[1];
  assign bass_chg    = tone_chg_q[0];
  assign treble_chg  = tone_chg_q[1];
  assign mute_chg    = mute_chg_q;
  assign tone_err    = |tone_err_q;

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable({att_q, tone_q, mute_q}));

  // R3
  mute_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (mute_on == $past(in_sub[MUTE_BIT])));

  // R3
  mute_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sub[MUTE_BIT]) |=> $stable({att_q, tone_q}));

  // R4
  vol_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_sub[3:2] != 2'b00)) |=> $stable(att_q));

  // R7
  tone_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_sub[1:0] != 2'b00)) |=> $stable(tone_q));

  // R5
  inf_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ch1_att_inf |-> (ch1_att_db == '1));

  // R8
  bass_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($signed(bass_db) >= -12) && ($signed(bass_db) <= 12) && !bass_db[0]);

  // R8
  treble_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($signed(treble_db) >= -12) && ($signed(treble_db) <= 12) && !treble_db[0]);

  // R9
  err_after_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tone_err |-> $past(in_valid));

  // R10
  bass_chg_real_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bass_chg |-> (bass_db != $past(bass_db)));

  // R10
  ch1_chg_real_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ch1_chg |-> ({ch1_att_inf, ch1_att_db} != $past({ch1_att_inf, ch1_att_db})));

  // R10
  mute_chg_real_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mute_chg |-> (mute_on != $past(mute_on)));
endmodule

// File: tb/avc_regs_top_tb_top.sv
module avc_regs_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_sub = '0;
  logic [7:0] in_data = '0;
  logic [6:0] ch1_att_db, ch2_att_db;
  logic       ch1_att_inf, ch2_att_inf;
  logic [4:0] bass_db, treble_db;
  logic       mute_on, ch1_chg, ch2_chg, bass_chg, treble_chg, mute_chg, tone_err;

  int  total = 0;
  int  bad = 0;
  bit  done = 0;

  // Reference state kept by the bench.
  int  m_db[2];
  bit  m_inf[2];
  int  m_bass, m_treb;
  bit  m_mute;

  always #2 clk = ~clk;

  avc_regs_top dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sub(in_sub), .in_data(in_data),
    .ch1_att_db(ch1_att_db), .ch1_att_inf(ch1_att_inf),
    .ch2_att_db(ch2_att_db), .ch2_att_inf(ch2_att_inf),
    .bass_db(bass_db), .treble_db(treble_db), .mute_on(mute_on),
    .ch1_chg(ch1_chg), .ch2_chg(ch2_chg), .bass_chg(bass_chg),
    .treble_chg(treble_chg), .mute_chg(mute_chg), .tone_err(tone_err)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic void ref_vol(input int n, input int f, output bit inf, output int db);
    int base;
    if (n == 31) begin
      inf = 1; db = 127;
    end else begin
      inf = 0;
      base = (n < 22) ? 2 * n : 46 + 4 * (n - 22);
      if (f >= 2 && base >= 42) f = 0;
      db = base + f;
    end
  endfunction

  function automatic int ref_tone(input int code, output bit ok);
    int mag = code % 8;
    bit neg = (code >= 8);
    ok = (mag <= 6) && !(neg && mag == 0);
    return neg ? -2 * mag : 2 * mag;
  endfunction

  task automatic check_state(input string tag, input bit p1, input bit p2, input bit pb,
                             input bit pt, input bit pm, input bit perr);
    chk(tag, "ch1_att_db", int'(ch1_att_db), m_db[0]);
    chk(tag, "ch1_att_inf", int'(ch1_att_inf), int'(m_inf[0]));
    chk(tag, "ch2_att_db", int'(ch2_att_db), m_db[1]);
    chk(tag, "ch2_att_inf", int'(ch2_att_inf), int'(m_inf[1]));
    chk(tag, "bass_db", int'($signed(bass_db)), m_bass);
    chk(tag, "treble_db", int'($signed(treble_db)), m_treb);
    chk(tag, "mute_on", int'(mute_on), int'(m_mute));
    chk(tag, "ch1_chg", int'(ch1_chg), int'(p1));
    chk(tag, "ch2_chg", int'(ch2_chg), int'(p2));
    chk(tag, "bass_chg", int'(bass_chg), int'(pb));
    chk(tag, "treble_chg", int'(treble_chg), int'(pt));
    chk(tag, "mute_chg", int'(mute_chg), int'(pm));
    chk(tag, "tone_err", int'(tone_err), int'(perr));
    chk(tag, "in_ready", int'(in_ready), 1);
  endtask

  // One transfer; the model is updated from the requirements, then every output is checked.
  task automatic xfer(input string tag, input logic [7:0] sub, input logic [7:0] data);
    bit p[2], pb, pt, pm, perr, vinf, ok;
    int vdb, g;
    bit vol_open  = !sub[4] && sub[3:2] == 2'b00;
    bit tone_open = !sub[4] && sub[1:0] == 2'b00;
    ref_vol(int'(data[4:0]), int'(data[6:5]), vinf, vdb);
    pb = 0; pt = 0; perr = 0;
    for (int c = 0; c < 2; c++) begin
      p[c] = 0;
      if (vol_open && sub[c]) begin
        p[c] = (vinf != m_inf[c]) || (vdb != m_db[c]);
        m_inf[c] = vinf; m_db[c] = vdb;
      end
    end
    if (tone_open && sub[2]) begin
      g = ref_tone(int'(data[3:0]), ok);
      if (ok) begin pb = (g != m_bass); m_bass = g; end else perr = 1;
    end
    if (tone_open && sub[3]) begin
      g = ref_tone(int'(data[7:4]), ok);
      if (ok) begin pt = (g != m_treb); m_treb = g; end else perr = 1;
    end
    pm = (sub[4] != m_mute);
    m_mute = sub[4];
    @(negedge clk);
    in_valid = 1'b1; in_sub = sub; in_data = data;
    @(negedge clk);
    in_valid = 1'b0;
    check_state(tag, p[0], p[1], pb, pt, pm, perr);
  endtask

  task automatic t_reset();
    m_db[0] = 127; m_db[1] = 127; m_inf[0] = 1; m_inf[1] = 1;
    m_bass = 0; m_treb = 0; m_mute = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_state("R1", 0, 0, 0, 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1", 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_idle();
    in_sub = 8'h0F; in_data = 8'h55;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check_state("R2", 0, 0, 0, 0, 0, 0);
    end
  endtask

  task automatic t_coarse_sweep();
    for (int n = 0; n < 32; n++) xfer("R5", 8'h03, 8'(n));
    for (int n = 30; n >= 0; n -= 3) xfer("R5", 8'h03, 8'(n));
  endtask

  task automatic t_fine();
    xfer("R6", 8'h03, {1'b0, 2'd3, 5'd5});
    xfer("R6", 8'h03, {1'b0, 2'd3, 5'd20});
    xfer("R6", 8'h03, {1'b0, 2'd2, 5'd21});
    xfer("R6", 8'h03, {1'b0, 2'd1, 5'd21});
    xfer("R6", 8'h03, {1'b0, 2'd3, 5'd25});
    xfer("R6", 8'h03, {1'b0, 2'd1, 5'd30});
    xfer("R6", 8'h03, {1'b0, 2'd3, 5'd31});
    xfer("R6", 8'h03, {1'b1, 2'd1, 5'd10});
    xfer("R6", 8'h03, {1'b0, 2'd1, 5'd10});
  endtask

  task automatic t_chan_select();
    xfer("R4", 8'h01, 8'd4);
    xfer("R4", 8'h02, 8'd9);
    xfer("R4", 8'h07, 8'd1);
    xfer("R4", 8'h0B, 8'd2);
    xfer("R4", 8'h00, 8'd3);
    xfer("R4", 8'h03, 8'd12);
  endtask

  task automatic t_tone();
    for (int v = 0; v < 16; v++) xfer("R8", 8'h04, {4'h0, 4'(v)});
    for (int v = 0; v < 16; v++) xfer("R8", 8'h08, {4'(v), 4'h0});
    xfer("R7", 8'h0C, 8'h3B);
    xfer("R7", 8'h0D, 8'h11);
    xfer("R7", 8'h06, 8'h22);
    xfer("R7", 8'h04, 8'h52);
  endtask

  task automatic t_unused();
    xfer("R9", 8'h0C, 8'h27);
    xfer("R9", 8'h0C, 8'hF4);
    xfer("R9", 8'h04, 8'h08);
    xfer("R9", 8'h08, 8'h83);
    @(negedge clk);
    check_state("R9", 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_mute();
    xfer("R3", 8'h10, 8'h00);
    xfer("R3", 8'h1F, 8'h1F);
    xfer("R3", 8'h13, 8'h05);
    xfer("R3", 8'h00, 8'h00);
  endtask

  task automatic t_no_change();
    xfer("R10", 8'h03, 8'd7);
    xfer("R10", 8'h03, 8'd7);
    xfer("R10", 8'h0C, 8'h24);
    xfer("R10", 8'h0C, 8'h24);
    xfer("R10", 8'h00, 8'h00);
    @(negedge clk);
    check_state("R10", 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_coarse_sweep();
    t_fine();
    t_chan_select();
    t_tone();
    t_unused();
    t_mute();
    t_idle();
    t_no_change();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule